// File: doc/BRIEF.md
# Shared-Port Fetch/Data Arbiter

This block sits at the front of a five-stage in-order pipeline in which instruction fetch and data access share one memory port. It owns the program counter and the fetch-to-decode pipeline register. In every cycle it looks at the instruction currently in the memory-access stage. A valid load or store gets the port. Any other instruction, or an empty memory stage, leaves the port to instruction fetch. When a data access and a fetch request meet in the same cycle, the data access wins. The older instruction keeps moving, and fetch is stalled for that cycle: the program counter and the fetch register payload hold, and a bubble (valid bit cleared) enters decode in place of a fetched instruction.

The memory port answers in the same cycle: `port_rdata` reflects `port_addr` combinationally, and a write takes effect on the clock edge. Instructions are 32 bits wide, and the program counter steps by 4 on every fetch that fires. Every pipeline register is edge-triggered with an asynchronous active-low reset. The memory-stage request is never back-pressured. The only back-pressure is on the fetch side: `fetch_stall` tells the upstream pipeline registers to hold, and the cleared `ifid_valid` marks the bubble. A saturating counter reports how many cycles were lost to port conflicts.

Top module: `sp_fetch_arb`

## Requirements
- R1: While reset is asserted and after it is released, `fetch_pc` equals RESET_PC (default 0), `ifid_valid` is 0 and `stall_count` is 0.
- R2: If `fetch_req`=1 and there is no data access, the port reads at `fetch_pc` with `port_we`=0. At the next edge `ifid_valid`=1, `ifid_instr` takes the value of `port_rdata`, `ifid_pc` takes the old `fetch_pc`, and `fetch_pc` advances by 4.
- R3: A data access is `mem_valid`=1 with `mem_op`=2'b01 (load) or 2'b10 (store). During a data access `port_en`=1 and `port_addr`=`mem_addr`. A store drives `port_we`=1 with `port_wdata`=`mem_wdata`. A load drives `port_we`=0, `ld_valid`=1 and `ld_data`=`port_rdata`. A value stored is returned by a later load from the same address.
- R4: A data access together with `fetch_req`=1 is a conflict. In that cycle `fetch_stall`=1. At the next edge `fetch_pc`, `ifid_pc` and `ifid_instr` keep their values and `ifid_valid` becomes 0.
- R5: `mem_op` 2'b00 or 2'b11 with `mem_valid`=1, or any `mem_op` with `mem_valid`=0, is not a data access. The port then serves fetch, and `port_we`, `ld_valid` and `fetch_stall` stay 0.
- R6: `stall_count` rises by one for each conflict cycle and only then. A data access without a fetch request does not count. The counter saturates at its all-ones value (CNT_W bits).
- R7: With `fetch_req`=0, `fetch_pc` holds, `ifid_valid` becomes 0 at the next edge, and `port_en` is 1 only for a data access.
- R8: N consecutive conflict cycles produce N bubbles with `fetch_pc` held throughout. The first fetch after them reads the held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch wants the port this cycle |
| mem_valid | input | 1 | Memory-stage slot holds an instruction |
| mem_op | input | 2 | 00 none, 01 load, 10 store, 11 none |
| mem_addr | input | ADDR_W | Data address from memory stage |
| mem_wdata | input | DATA_W | Store data from memory stage |
| ld_valid | output | 1 | Load data is being returned this cycle |
| ld_data | output | DATA_W | Load data for the memory stage |
| port_en | output | 1 | Memory port access enable |
| port_we | output | 1 | Memory port write enable |
| port_addr | output | ADDR_W | Memory port address |
| port_wdata | output | DATA_W | Memory port write data |
| port_rdata | input | DATA_W | Memory port read data, same cycle |
| fetch_stall | output | 1 | Hold upstream registers; bubble injected |
| fetch_pc | output | ADDR_W | Current program counter |
| ifid_valid | output | 1 | Fetch register holds a real instruction |
| ifid_instr | output | DATA_W | Fetched instruction |
| ifid_pc | output | ADDR_W | Address of the fetched instruction |
| stall_count | output | CNT_W | Saturating count of conflict cycles |

## Verification
The bench goes after the conflict cycle. If the design let fetch win, the program counter would advance past a load and that instruction would be lost. If the design left a stale valid bit, the same instruction would be decoded twice. Reserved and idle memory-stage codes are driven to catch an arbiter that grants the port to any valid slot; such a design would stall fetch and mis-steer the address. Runs of back-to-back loads and stores, data accesses with fetch idle, a store followed by a load to the same address, and enough conflicts to saturate a narrow counter check that bubbles, held state and the conflict count stay exact.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } mem_op_e;

  function automatic logic is_data_op(input logic [1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/sp_arb_grant.sv
module sp_arb_grant
  import sp_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              fetch_req,
  input  logic              mem_valid,
  input  logic [1:0]        mem_op,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] pc,
  output logic              data_sel,
  output logic              fetch_fire,
  output logic              conflict,
  output logic              load_sel,
  output logic              port_en,
  output logic              port_we,
  output logic [ADDR_W-1:0] port_addr,
  output logic [DATA_W-1:0] port_wdata
);
  logic store_sel;

  always_comb begin
    data_sel   = mem_valid && is_data_op(mem_op);
    load_sel   = data_sel && (mem_op == OP_LOAD);
    store_sel  = data_sel && (mem_op == OP_STORE);
    conflict   = data_sel && fetch_req;
    fetch_fire = fetch_req && !data_sel;
    port_en    = data_sel || fetch_req;
    port_we    = store_sel;
    port_addr  = data_sel ? mem_addr : pc;
    port_wdata = store_sel ? mem_wdata : '0;
  end
endmodule

// File: rtl/sp_arb_pc.sv
module sp_arb_pc #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter int              PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_PC;
    else if (advance) pc <= pc + STEP;
  end
endmodule

// File: rtl/sp_arb_ifid.sv
module sp_arb_ifid #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] instr_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              valid_q,
  output logic [DATA_W-1:0] instr_q,
  output logic [ADDR_W-1:0] pc_q
);
  // valid follows load_en every cycle; payload only moves when loaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      instr_q <= '0;
      pc_q    <= '0;
    end else begin
      valid_q <= load_en;
      if (load_en) begin
        instr_q <= instr_in;
        pc_q    <= pc_in;
      end
    end
  end
endmodule

// File: rtl/sp_arb_stallcnt.sv
module sp_arb_stallcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (hit && (count != CNT_MAX)) count <= count + 1'b1;
  end
endmodule

// File: rtl/sp_fetch_arb.sv
module sp_fetch_arb #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter int                PC_STEP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              mem_valid,
  input  logic [1:0]        mem_op,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              port_en,
  output logic              port_we,
  output logic [ADDR_W-1:0] port_addr,
  output logic [DATA_W-1:0] port_wdata,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              fetch_stall,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              ifid_valid,
  output logic [DATA_W-1:0] ifid_instr,
  output logic [ADDR_W-1:0] ifid_pc,
  output logic [CNT_W-1:0]  stall_count
);
  logic data_sel, fetch_fire, conflict, load_sel;

  sp_arb_grant #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_grant (
    .fetch_req (fetch_req),
    .mem_valid (mem_valid),
    .mem_op    (mem_op),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc        (fetch_pc),
    .data_sel  (data_sel),
    .fetch_fire(fetch_fire),
    .conflict  (conflict),
    .load_sel  (load_sel),
    .port_en   (port_en),
    .port_we   (port_we),
    .port_addr (port_addr),
    .port_wdata(port_wdata)
  );

  sp_arb_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(fetch_fire),
    .pc     (fetch_pc)
  );

  sp_arb_ifid #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ifid (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (fetch_fire),
    .instr_in(port_rdata),
    .pc_in   (fetch_pc),
    .valid_q (ifid_valid),
    .instr_q (ifid_instr),
    .pc_q    (ifid_pc)
  );

  sp_arb_stallcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (conflict),
    .count(stall_count)
  );

  assign fetch_stall = conflict;
  assign ld_valid    = load_sel;
  assign ld_data     = load_sel ? port_rdata : '0;
endmodule

// File: rtl/sp_fetch_arb_chk.sv
module sp_fetch_arb_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int PC_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic              mem_valid,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ld_valid,
  input logic              port_en,
  input logic              port_we,
  input logic [ADDR_W-1:0] port_addr,
  input logic              fetch_stall,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              ifid_valid,
  input logic [DATA_W-1:0] ifid_instr,
  input logic [ADDR_W-1:0] ifid_pc,
  input logic [CNT_W-1:0]  stall_count
);
  logic is_dacc;
  assign is_dacc = mem_valid && (mem_op == 2'b01 || mem_op == 2'b10);

  assert_data_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_dacc |-> (port_en && port_addr == mem_addr && port_we == (mem_op == 2'b10)));

  assert_no_stray_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dacc |-> (!port_we && !ld_valid && !fetch_stall));

  assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !is_dacc) |=> (ifid_valid && fetch_pc == $past(fetch_pc) + ADDR_W'(PC_STEP)
                                 && ifid_pc == $past(fetch_pc)));

  assert_bubble_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> (!ifid_valid && $stable(fetch_pc) && $stable(ifid_pc) && $stable(ifid_instr)));

  assert_stall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> (fetch_req && is_dacc));

  assert_cnt_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && stall_count != '1) |=> stall_count == $past(stall_count) + 1'b1);

  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall |=> $stable(stall_count));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> (!ifid_valid && $stable(fetch_pc)));
endmodule

bind sp_fetch_arb sp_fetch_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PC_STEP(PC_STEP)
) u_chk (.*);

// File: tb/sp_fetch_arb_bench.sv
module sp_fetch_arb_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 1'b0, mem_valid = 1'b0;
  logic [1:0] mem_op = 2'b00;
  logic [AW-1:0] mem_addr = '0;
  logic [DW-1:0] mem_wdata = '0;
  logic ld_valid, port_en, port_we, fetch_stall, ifid_valid;
  logic [DW-1:0] ld_data, port_wdata, port_rdata, ifid_instr;
  logic [AW-1:0] port_addr, fetch_pc, ifid_pc;
  logic [CW-1:0] stall_count;

  always #5 clk = ~clk;

  sp_fetch_arb #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_sp_fetch_arb (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .mem_valid(mem_valid),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .port_en(port_en), .port_we(port_we),
    .port_addr(port_addr), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .fetch_stall(fetch_stall), .fetch_pc(fetch_pc), .ifid_valid(ifid_valid),
    .ifid_instr(ifid_instr), .ifid_pc(ifid_pc), .stall_count(stall_count)
  );

  // shared memory model: combinational read, write on edge
  logic [DW-1:0] ram [0:255];
  initial for (int i = 0; i < 256; i++) ram[i] = (i * 32'h0101_0101) ^ 32'hC0DE_0000;
  assign port_rdata = ram[port_addr[9:2]];
  always @(posedge clk) if (port_en && port_we) ram[port_addr[9:2]] <= port_wdata;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic v; logic [DW-1:0] instr; logic [AW-1:0] ipc; logic [AW-1:0] pc;
    logic [CW-1:0] cnt; string tag;
  } exp_t;
  exp_t sb[$];

  logic [AW-1:0] e_pc = '0, e_ipc = '0;
  logic [DW-1:0] e_instr = '0;
  logic [CW-1:0] e_cnt = '0;

  // driver: apply one cycle of stimulus, check same-cycle outputs, push next-state expectation
  task automatic step(input logic fr, input logic mv, input logic [1:0] op,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    bit dacc, st;
    exp_t e;
    @(negedge clk);
    fetch_req = fr; mem_valid = mv; mem_op = op; mem_addr = a; mem_wdata = wd;
    #1;
    dacc = mv && (op == 2'b01 || op == 2'b10);
    st = dacc && fr;
    check(port_en == (dacc || fr), {tag, " port_en"}, port_en, dacc || fr);
    if (dacc || fr)
      check(port_addr == (dacc ? a : e_pc), {tag, " port_addr"}, port_addr, dacc ? a : e_pc);
    check(port_we == (dacc && op == 2'b10), {tag, " port_we"}, port_we, dacc && op == 2'b10);
    if (dacc && op == 2'b10) check(port_wdata == wd, {tag, " port_wdata"}, port_wdata, wd);
    check(fetch_stall == st, {tag, " fetch_stall"}, fetch_stall, st);
    check(ld_valid == (dacc && op == 2'b01), {tag, " ld_valid"}, ld_valid, dacc && op == 2'b01);
    if (dacc && op == 2'b01)
      check(ld_data == ram[a[9:2]], {tag, " ld_data"}, ld_data, ram[a[9:2]]);
    if (fr && !dacc) begin
      e_instr = ram[e_pc[9:2]];
      e_ipc = e_pc;
      e_pc = e_pc + 4;
      e.v = 1'b1;
    end else e.v = 1'b0;
    if (st && e_cnt != '1) e_cnt = e_cnt + 1'b1;
    e.instr = e_instr; e.ipc = e_ipc; e.pc = e_pc; e.cnt = e_cnt; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare registered state after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(ifid_valid == e.v, {e.tag, " ifid_valid"}, ifid_valid, e.v);
      check(fetch_pc == e.pc, {e.tag, " fetch_pc"}, fetch_pc, e.pc);
      check(ifid_pc == e.ipc, {e.tag, " ifid_pc"}, ifid_pc, e.ipc);
      check(ifid_instr == e.instr, {e.tag, " ifid_instr"}, ifid_instr, e.instr);
      check(stall_count == e.cnt, {e.tag, " stall_count"}, stall_count, e.cnt);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(fetch_pc == 0, "R1 pc in reset", fetch_pc, 0);
    check(ifid_valid == 0, "R1 valid in reset", ifid_valid, 0);
    check(stall_count == 0, "R1 count in reset", stall_count, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(fetch_pc == 0 && ifid_valid == 0, "R1 after release", fetch_pc, 0);

    for (int i = 0; i < 6; i++) step(1, 0, 2'b00, '0, '0, "R2 plain fetch");
    step(1, 1, 2'b00, 32'h240, '0, "R5 op none");
    step(1, 1, 2'b11, 32'h244, '0, "R5 op reserved");
    step(1, 0, 2'b01, 32'h248, '0, "R5 load not valid");
    step(1, 0, 2'b10, 32'h24C, 32'hDEAD, "R5 store not valid");
    step(1, 1, 2'b01, 32'h210, '0, "R4 load conflict");
    step(1, 0, 2'b00, '0, '0, "R2 resume");
    step(1, 1, 2'b10, 32'h220, 32'h1234_5678, "R4 store conflict");
    step(1, 1, 2'b01, 32'h220, '0, "R3 load after store");
    step(1, 0, 2'b00, '0, '0, "R2 resume");
    step(1, 1, 2'b01, 32'h300, '0, "R8 run 1");
    step(1, 1, 2'b10, 32'h304, 32'hA5A5_0001, "R8 run 2");
    step(1, 1, 2'b01, 32'h304, '0, "R8 run 3");
    step(1, 0, 2'b00, '0, '0, "R8 first fetch after run");
    step(0, 1, 2'b01, 32'h308, '0, "R6 load without fetch");
    step(0, 1, 2'b10, 32'h30C, 32'h7777, "R7 store while idle");
    step(0, 0, 2'b00, '0, '0, "R7 idle");
    step(0, 1, 2'b11, '0, '0, "R7 idle reserved");
    step(1, 0, 2'b00, '0, '0, "R2 fetch after idle");
    for (int i = 0; i < 14; i++) step(1, 1, 2'b01, 32'h280, '0, "R6 saturate");
    step(1, 0, 2'b00, '0, '0, "R6 after saturation");
    repeat (3) @(posedge clk);
    #3;
    check(stall_count == 4'hF, "R6 saturated value", stall_count, 4'hF);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule